// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Logic

This block connects a small set of peripheral interrupt sources to a single active-high processor interrupt line. Each source owns one stage of a serial chain. A pulse on a stage's event input sets a registered pending flag. The OR of all pending flags drives the processor's interrupt request.

When the processor answers, it drives an active-low acknowledge into stage 0, the most urgent position. The acknowledge ripples combinationally down the chain. The first stage holding a pending flag keeps it and blocks it from every stage behind it. That stage raises its grant line and places its own 8-bit vector on the shared vector bus, which the processor uses to find the service routine.

When the acknowledge is released, the granted stage's flag clears, so less urgent stages can be served on the following acknowledge. An acknowledge that runs off the end of the chain unclaimed raises a spurious indication and puts a default vector on the bus.

Top module: `irq_daisy_chain`

## Requirements
- R1: A high `dev_event[i]` at a clock edge sets stage i's pending flag at that edge. `irq` is high exactly when at least one pending flag is set.
- R2: The acknowledge `ack_n` is active low. While `ack_n` is high, `grant` is all zeros, `spurious` is 0 and `vector` is 8'h00.
- R3: While `ack_n` is low, the granted stage is the lowest-index stage whose pending flag is set. Stage 0 has the highest priority.
- R4: At most one bit of `grant` is high at any time. No stage with a higher index than a pending stage is ever granted.
- R5: While stage i is granted, `vector` equals byte i of `STAGE_VEC`, taken from bits 8i+7 down to 8i. By default stage i's vector is 8'h40 + i.
- R6: While `ack_n` is low and no flag is pending, `spurious` is 1, `grant` is zero and `vector` equals `SPUR_VEC`, which defaults to 8'hFF.
- R7: The release edge is the first clock edge at which `ack_n` is sampled high after it was sampled low. At that edge, the flag of the stage that was granted at the previous edge clears. All other flags keep their values.
- R8: If `dev_event[i]` is high on the release edge that would clear stage i, the flag stays set.
- R9: After a synchronous reset with `rst_n` low, every pending flag is clear, so `irq` is 0 and `grant` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_event | input | N | Per-stage request event from the peripherals |
| ack_n | input | 1 | Processor interrupt acknowledge, active low |
| irq | output | 1 | Combined interrupt request, active high |
| grant | output | N | Per-stage accepted flag |
| vector | output | 8 | Vector of the accepting stage, a default, or zero |
| spurious | output | 1 | Acknowledge left the chain unclaimed |

## Verification
The bench targets several corner cases:
- Several stages pending at once, where a chain that forwarded past a pending stage would grant two stages or the wrong one.
- An acknowledge with nothing pending, where a broken tail check would leave the vector bus at zero instead of the default.
- The release edge itself, where clearing the wrong stage or clearing every flag would lose requests.
- An event arriving on that same release edge, where giving the clear priority would drop the new request.

Long random runs mix event bursts with acknowledges of varying length, so that requests are served in a changing order.

// File: rtl/irq_chain_pkg.sv
// Shared constants and types for the daisy-chain interrupt logic.
package irq_chain_pkg;
    localparam int VEC_W      = 8;
    localparam int MAX_STAGES = 8;
    typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_chain_stage.sv
// One chain position. Holds the pending flag for its peripheral, claims an
// acknowledge arriving while the flag is set, and otherwise forwards it.
// Assumes release_evt is a single-cycle strobe marking the release edge.
module irq_chain_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic ack_in_n,
    input  logic release_evt,
    output logic ack_out_n,
    output logic claim,
    output logic pending
);
    logic pend_q;
    logic claim_q;

    // Pending flag: a new event wins over the release clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_q <= 1'b0;
        else if (req_set)                 pend_q <= 1'b1;
        else if (release_evt && claim_q)  pend_q <= 1'b0;
    end

    // Remember whether this stage held the acknowledge in the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) claim_q <= 1'b0;
        else        claim_q <= claim;
    end

    // Claim or forward the acknowledge combinationally.
    always_comb begin
        claim     = ~ack_in_n & pend_q;
        ack_out_n = ack_in_n | pend_q;
    end

    assign pending = pend_q;
endmodule

// File: rtl/irq_vector_sel.sv
// Drives the shared vector bus: the vector of the granted stage, the default
// vector on a spurious acknowledge, and zero otherwise. Assumes grant is
// one-hot or zero.
module irq_vector_sel #(
    parameter int N = 4,
    parameter logic [8*irq_chain_pkg::MAX_STAGES-1:0] STAGE_VEC = 64'h4746454443424140,
    parameter logic [7:0] SPUR_VEC = 8'hFF
) (
    input  logic [N-1:0]               grant,
    input  logic                       spurious,
    output irq_chain_pkg::vec_t        vector
);
    // OR together the vectors of the granted stages, or select the default.
    always_comb begin
        vector = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) vector = vector | STAGE_VEC[8*i +: 8];
        end
        if (spurious) vector = SPUR_VEC;
    end
endmodule

// File: rtl/irq_daisy_chain.sv
// Top of the daisy-chain interrupt logic. Merges the per-stage pending flags
// into one interrupt request, threads the active-low acknowledge through N
// stages (stage 0 first), and flags an acknowledge nobody claimed.
// Assumes 2 <= N <= 8 and that ack_n is synchronous to clk.
module irq_daisy_chain #(
    parameter int N = 4,
    parameter logic [8*irq_chain_pkg::MAX_STAGES-1:0] STAGE_VEC = 64'h4746454443424140,
    parameter logic [7:0] SPUR_VEC = 8'hFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dev_event,
    input  logic         ack_n,
    output logic         irq,
    output logic [N-1:0] grant,
    output logic [7:0]   vector,
    output logic         spurious
);
    logic [N:0]   ack_chain_n;
    logic [N-1:0] pend_vec;
    logic         ack_q;
    logic         release_evt;

    // Track the acknowledge to find its rising (release) edge.
    always_ff @(posedge clk) begin
        if (!rst_n) ack_q <= 1'b1;
        else        ack_q <= ack_n;
    end

    assign release_evt    = ack_n & ~ack_q;
    assign ack_chain_n[0] = ack_n;

    // One stage per source, chained in priority order.
    for (genvar g = 0; g < N; g++) begin : g_stage
        irq_chain_stage u_stage (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_set     (dev_event[g]),
            .ack_in_n    (ack_chain_n[g]),
            .release_evt (release_evt),
            .ack_out_n   (ack_chain_n[g+1]),
            .claim       (grant[g]),
            .pending     (pend_vec[g])
        );
    end

    assign irq      = |pend_vec;
    assign spurious = ~ack_chain_n[N];

    irq_vector_sel #(
        .N         (N),
        .STAGE_VEC (STAGE_VEC),
        .SPUR_VEC  (SPUR_VEC)
    ) u_vsel (
        .grant    (grant),
        .spurious (spurious),
        .vector   (vector)
    );
endmodule

// File: rtl/irq_daisy_chain_chk.sv
// Property checker for irq_daisy_chain, attached through bind.
module irq_daisy_chain_chk #(
    parameter int N = 4,
    parameter logic [7:0] SPUR_VEC = 8'hFF
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] dev_event,
    input logic         ack_n,
    input logic         irq,
    input logic [N-1:0] grant,
    input logic [7:0]   vector,
    input logic         spurious,
    input logic [N-1:0] pend
);
    // R1: an event makes the request line high one cycle later
    a_r1_event_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_event != '0) |=> irq);

    // R2: nothing is driven while the acknowledge is inactive
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |-> (grant == '0 && !spurious && vector == 8'h00));

    // R3: the first stage wins whenever it is pending
    a_r3_head_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && pend[0]) |-> grant[0]);

    // R4: a single acceptor at most
    a_r4_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: an unclaimed acknowledge yields the default vector
    a_r6_spurious_default: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && pend == '0) |-> (spurious && grant == '0 && vector == SPUR_VEC));

    // R7: after release, the previously granted flag is gone unless re-raised
    a_r7_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n) |=> ((pend & $past(grant, 2) & ~$past(dev_event)) == '0));
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(.N(N), .SPUR_VEC(SPUR_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_event (dev_event),
    .ack_n     (ack_n),
    .irq       (irq),
    .grant     (grant),
    .vector    (vector),
    .spurious  (spurious),
    .pend      (pend_vec)
);

// File: tb/irq_daisy_chain_bench.sv
`timescale 1ns/100ps
module irq_daisy_chain_bench;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] dev_event;
    logic         ack_n;
    logic         irq;
    logic [N-1:0] grant;
    logic [7:0]   vector;
    logic         spurious;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [N-1:0] pend_m;
    logic [N-1:0] grantq_m;
    logic         ackq_m;

    always #2.5 clk = ~clk;

    irq_daisy_chain #(.N(N)) u_irq_daisy_chain (
        .clk(clk), .rst_n(rst_n), .dev_event(dev_event), .ack_n(ack_n),
        .irq(irq), .grant(grant), .vector(vector), .spurious(spurious)
    );

    // Expected grant: lowest pending index while acknowledged (R3, R4).
    function automatic logic [N-1:0] exp_grant(logic [N-1:0] p, logic a);
        logic [N-1:0] r = '0;
        if (!a) begin
            for (int i = N-1; i >= 0; i--) if (p[i]) r = '0 | (1 << i);
        end
        return r;
    endfunction

    // Expected vector bus (R2, R5, R6).
    function automatic logic [7:0] exp_vec(logic [N-1:0] p, logic a);
        logic [7:0] v = 8'h00;
        if (!a) begin
            v = 8'hFF;
            for (int i = N-1; i >= 0; i--) if (p[i]) v = 8'h40 + 8'(i);
        end
        return v;
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle, compare outputs, advance the model across the edge.
    task automatic cycle(logic [N-1:0] ev, logic a, string tag);
        logic rel;
        dev_event = ev;
        ack_n     = a;
        #1;
        chk(tag, "irq R1", {7'b0, irq}, {7'b0, |pend_m});
        chk(tag, "grant R3", {4'b0, grant}, {4'b0, exp_grant(pend_m, a)});
        chk(tag, "vector R5", vector, exp_vec(pend_m, a));
        chk(tag, "spurious R6", {7'b0, spurious}, {7'b0, (!a && pend_m == '0)});
        @(posedge clk);
        rel      = a & ~ackq_m;
        pend_m   = ev | (pend_m & ~(rel ? grantq_m : '0));
        grantq_m = exp_grant(pend_m | '0, 1'b1) | exp_grant(pend_m, 1'b1);
        #1;
    endtask

    // Model update of grant history uses pre-edge values; recompute here.
    task automatic cycle_m(logic [N-1:0] ev, logic a, string tag);
        logic [N-1:0] g_before;
        g_before = exp_grant(pend_m, a);
        cycle(ev, a, tag);
        grantq_m = g_before;
        ackq_m   = a;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; dev_event = '0; ack_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        pend_m = '0; grantq_m = '0; ackq_m = 1'b1;
        chk("R9", "irq after reset", {7'b0, irq}, 8'h00);
        chk("R9", "grant after reset", {4'b0, grant}, 8'h00);
        rst_n = 1'b1;

        cycle_m(4'b1010, 1'b1, "R1");
        cycle_m(4'b0000, 1'b1, "R1");
        cycle_m(4'b0000, 1'b0, "R3");
        cycle_m(4'b0000, 1'b0, "R4");
        cycle_m(4'b0000, 1'b1, "R7");
        cycle_m(4'b0000, 1'b0, "R7");
        cycle_m(4'b1000, 1'b1, "R8");
        cycle_m(4'b0000, 1'b0, "R8");
        cycle_m(4'b0000, 1'b1, "R2");
        cycle_m(4'b0000, 1'b0, "R6");
        cycle_m(4'b1111, 1'b1, "R2");
        cycle_m(4'b0000, 1'b0, "R3");
        cycle_m(4'b0000, 1'b1, "R7");
        cycle_m(4'b0000, 1'b0, "R5");
        cycle_m(4'b0000, 1'b1, "R7");

        for (int k = 0; k < 2000; k++) begin
            logic [N-1:0] ev;
            logic a;
            ev = (($urandom % 4) == 0) ? N'($urandom) : '0;
            a  = (($urandom % 3) == 0) ? ~ack_n : ack_n;
            cycle_m(ev, a, "RND");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule